// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block forecasts whether a conditional branch will be taken. Two predictors run side by side. The first keeps a short outcome history for each branch slot. It uses that history to pick a 3-bit saturating counter. The second uses a global register of recent resolved outcomes to pick a 2-bit counter. A third table of 2-bit choice counters, also indexed by the global register, learns which of the two to trust.

The fetch side presents a PC. In the same cycle it receives the taken/not-taken forecast, along with a snapshot: the local history and global history used as indices, plus each predictor's individual vote. When the branch resolves, the pipeline returns the PC, the real outcome and that snapshot. Training then hits exactly the entries that produced the forecast. The global register is rebuilt from the returned snapshot, so a wrong-path history is repaired by the resolve.

After reset, a small state machine walks every table and writes its initial value, one index per cycle. The states are TP_CLEAR and TP_RUN. Reset enters TP_CLEAR. TP_CLEAR loops on itself while the sweep index is below its last value. It moves to TP_RUN on the cycle that writes the last index. TP_RUN holds until the next reset.

Top module: `tournament_predictor`

## Requirements
- R1: After reset, `ready` stays low for exactly 2^max(LIDX_W, LHIST_LEN, GHIST_LEN) rising edges and then stays high until reset. While it is low, `pred_taken` is 0 and any resolve is ignored.
- R2: The local history slot is selected by `fetch_pc[PC_LSB +: LIDX_W]`, and `pred_lhist` shows that slot's contents. Every slot holds all zeros after the clear.
- R3: Local counters are LCTR_W (3) bits wide and start at 3. A counter votes taken (`pred_lpred` = 1) when its value is 4 or more. Counters stay within 0..7.
- R4: Global counters are GCTR_W (2) bits wide, indexed by the global history register, and start at 1. A counter votes taken (`pred_gpred` = 1) when its value is 2 or more. Counters stay within 0..3.
- R5: Choice counters are 2 bits wide and start at 2. A value of 2 or more selects the global vote for `pred_taken`; a lower value selects the local vote.
- R6: The global history register starts at 0 and is shown on `pred_ghist`. On an accepted resolve it becomes `{res_ghist[GHIST_LEN-2:0], res_taken}`, with the newest outcome at bit 0. Otherwise it holds.
- R7: On an accepted resolve, the local history slot chosen by `res_pc` becomes `{res_lhist[LHIST_LEN-2:0], res_taken}`.
- R8: On an accepted resolve, the local counter at index `res_lhist` and the global counter at index `res_ghist` each step by one toward `res_taken`, saturating at both ends.
- R9: On an accepted resolve where `res_lpred` differs from `res_gpred`, the choice counter at `res_ghist` steps one toward global if `res_gpred` equals `res_taken`, and one toward local otherwise. When the two votes agree, the choice counter is left unchanged.
- R10: The forecast outputs are combinational from `fetch_pc` and the current table contents. A resolve accepted at a rising edge is visible to forecasts from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, starts the table sweep |
| ready | output | 1 | High once the sweep has finished |
| fetch_pc | input | PC_W | PC of the branch being forecast |
| pred_taken | output | 1 | Final forecast |
| pred_lhist | output | LHIST_LEN | Snapshot: local history used as index |
| pred_ghist | output | GHIST_LEN | Snapshot: global history used as index |
| pred_lpred | output | 1 | Snapshot: local vote |
| pred_gpred | output | 1 | Snapshot: global vote |
| res_valid | input | 1 | A resolve is presented this cycle |
| res_pc | input | PC_W | PC of the resolved branch |
| res_taken | input | 1 | Real outcome |
| res_lhist | input | LHIST_LEN | Returned local history snapshot |
| res_ghist | input | GHIST_LEN | Returned global history snapshot |
| res_lpred | input | 1 | Returned local vote |
| res_gpred | input | 1 | Returned global vote |

## Verification
The bench drives long runs of one outcome on a single branch. These runs push the local and global counters into both saturation limits. A counter that wrapped instead of saturating would flip its vote after one more step. Resolves are presented throughout the clear sweep. A design that trained during the sweep would show a nonzero history or counter once ready rises.

About a quarter of the resolves carry a stale snapshot from an earlier forecast. A design that trained at the indices of the current history, rather than the returned ones, would diverge from the model. It would also fail to restore the global register. Disagreeing and agreeing local and global votes both occur. A chooser that moved on agreement, or moved the wrong way, would change which vote reaches `pred_taken`.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef enum logic [0:0] {
        TP_CLEAR = 1'b0,
        TP_RUN   = 1'b1
    } tp_state_e;

    function automatic int tp_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/tp_sat_table.sv
// Table of saturating counters: combinational read of the top bit,
// one sweep write for initialisation, one training write per cycle.
module tp_sat_table #(
    parameter int IDX_W    = 4,
    parameter int CTR_W    = 2,
    parameter int INIT_VAL = 1
) (
    input  logic             clk,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_hi,
    input  logic             up_en,
    input  logic [IDX_W-1:0] up_idx,
    input  logic             up_dir
);
    localparam int               DEPTH  = 1 << IDX_W;
    localparam logic [CTR_W-1:0] C_MAX  = '1;
    localparam logic [CTR_W-1:0] C_MIN  = '0;
    localparam logic [CTR_W-1:0] C_INIT = CTR_W'(INIT_VAL);

    logic [CTR_W-1:0] mem [DEPTH];
    logic [CTR_W-1:0] cur_val;
    logic [CTR_W-1:0] nxt_val;

    always_comb begin
        cur_val = mem[up_idx];
        if (up_dir) begin
            nxt_val = (cur_val == C_MAX) ? cur_val : cur_val + 1'b1;
        end else begin
            nxt_val = (cur_val == C_MIN) ? cur_val : cur_val - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (clr_en) begin
            mem[clr_idx] <= C_INIT;
        end else if (up_en) begin
            mem[up_idx] <= nxt_val;
        end
    end

    assign rd_hi = mem[rd_idx][CTR_W-1];

endmodule

// File: rtl/tp_hist_table.sv
// Per-slot outcome histories. Training rebuilds the entry from the
// returned snapshot with the real outcome shifted in at bit 0.
module tp_hist_table #(
    parameter int IDX_W  = 3,
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              up_en,
    input  logic [IDX_W-1:0]  up_idx,
    input  logic [HIST_W-2:0] up_base,
    input  logic              up_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (clr_en) begin
            mem[clr_idx] <= '0;
        end else if (up_en) begin
            mem[up_idx] <= {up_base, up_bit};
        end
    end

    assign rd_hist = mem[rd_idx];

endmodule

// File: rtl/tp_chooser.sv
// Final selection between the two votes, and the training decision
// for the choice counter.
module tp_chooser (
    input  logic ready,
    input  logic sel_global,
    input  logic lvote,
    input  logic gvote,
    output logic final_vote,
    input  logic upd_en,
    input  logic upd_lvote,
    input  logic upd_gvote,
    input  logic upd_taken,
    output logic ch_en,
    output logic ch_dir
);
    logic picked;

    always_comb begin
        picked     = sel_global ? gvote : lvote;
        final_vote = ready & picked;
    end

    always_comb begin
        ch_en  = upd_en && (upd_lvote != upd_gvote);
        ch_dir = (upd_gvote == upd_taken);
    end

endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
    import tp_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int LIDX_W    = 10,
    parameter int LHIST_LEN = 10,
    parameter int GHIST_LEN = 12,
    parameter int LCTR_W    = 3,
    parameter int GCTR_W    = 2,
    parameter int CCTR_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 ready,
    input  logic [PC_W-1:0]      fetch_pc,
    output logic                 pred_taken,
    output logic [LHIST_LEN-1:0] pred_lhist,
    output logic [GHIST_LEN-1:0] pred_ghist,
    output logic                 pred_lpred,
    output logic                 pred_gpred,
    input  logic                 res_valid,
    input  logic [PC_W-1:0]      res_pc,
    input  logic                 res_taken,
    input  logic [LHIST_LEN-1:0] res_lhist,
    input  logic [GHIST_LEN-1:0] res_ghist,
    input  logic                 res_lpred,
    input  logic                 res_gpred
);
    localparam int CLR_W     = tp_max3(LIDX_W, LHIST_LEN, GHIST_LEN);
    localparam int LCTR_INIT = (1 << (LCTR_W - 1)) - 1;
    localparam int GCTR_INIT = (1 << (GCTR_W - 1)) - 1;
    localparam int CCTR_INIT = 1 << (CCTR_W - 1);
    localparam logic [CLR_W-1:0] CLR_LAST = '1;

    tp_state_e          state_q, state_d;
    logic [CLR_W-1:0]   clr_q;
    logic [GHIST_LEN-1:0] ghr_q;
    logic               clr_en;
    logic               upd_en;
    logic               sel_global;
    logic               ch_en;
    logic               ch_dir;
    logic [LIDX_W-1:0]  fetch_slot;
    logic [LIDX_W-1:0]  res_slot;
    logic               pc_unused;

    assign fetch_slot = fetch_pc[PC_LSB +: LIDX_W];
    assign res_slot   = res_pc[PC_LSB +: LIDX_W];
    assign pc_unused  = ^{fetch_pc, res_pc};

    // state register and sweep index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TP_CLEAR;
            clr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TP_CLEAR) begin
                clr_q <= clr_q + 1'b1;
            end
        end
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TP_CLEAR: if (clr_q == CLR_LAST) state_d = TP_RUN;
            TP_RUN:   state_d = TP_RUN;
            default:  state_d = TP_CLEAR;
        endcase
    end

    // state outputs
    always_comb begin
        clr_en = 1'b0;
        upd_en = 1'b0;
        ready  = 1'b0;
        unique case (state_q)
            TP_CLEAR: clr_en = 1'b1;
            TP_RUN: begin
                ready  = 1'b1;
                upd_en = res_valid;
            end
            default: clr_en = 1'b1;
        endcase
    end

    // global history register, rebuilt from the returned snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ghr_q <= '0;
        end else if (upd_en) begin
            ghr_q <= {res_ghist[GHIST_LEN-2:0], res_taken};
        end
    end

    assign pred_ghist = ghr_q;

    tp_hist_table #(
        .IDX_W  (LIDX_W),
        .HIST_W (LHIST_LEN)
    ) u_lhist (
        .clk     (clk),
        .clr_en  (clr_en),
        .clr_idx (clr_q[LIDX_W-1:0]),
        .rd_idx  (fetch_slot),
        .rd_hist (pred_lhist),
        .up_en   (upd_en),
        .up_idx  (res_slot),
        .up_base (res_lhist[LHIST_LEN-2:0]),
        .up_bit  (res_taken)
    );

    tp_sat_table #(
        .IDX_W    (LHIST_LEN),
        .CTR_W    (LCTR_W),
        .INIT_VAL (LCTR_INIT)
    ) u_lctr (
        .clk     (clk),
        .clr_en  (clr_en),
        .clr_idx (clr_q[LHIST_LEN-1:0]),
        .rd_idx  (pred_lhist),
        .rd_hi   (pred_lpred),
        .up_en   (upd_en),
        .up_idx  (res_lhist),
        .up_dir  (res_taken)
    );

    tp_sat_table #(
        .IDX_W    (GHIST_LEN),
        .CTR_W    (GCTR_W),
        .INIT_VAL (GCTR_INIT)
    ) u_gctr (
        .clk     (clk),
        .clr_en  (clr_en),
        .clr_idx (clr_q[GHIST_LEN-1:0]),
        .rd_idx  (ghr_q),
        .rd_hi   (pred_gpred),
        .up_en   (upd_en),
        .up_idx  (res_ghist),
        .up_dir  (res_taken)
    );

    tp_sat_table #(
        .IDX_W    (GHIST_LEN),
        .CTR_W    (CCTR_W),
        .INIT_VAL (CCTR_INIT)
    ) u_cctr (
        .clk     (clk),
        .clr_en  (clr_en),
        .clr_idx (clr_q[GHIST_LEN-1:0]),
        .rd_idx  (ghr_q),
        .rd_hi   (sel_global),
        .up_en   (ch_en),
        .up_idx  (res_ghist),
        .up_dir  (ch_dir)
    );

    tp_chooser u_choose (
        .ready      (ready),
        .sel_global (sel_global),
        .lvote      (pred_lpred),
        .gvote      (pred_gpred),
        .final_vote (pred_taken),
        .upd_en     (upd_en),
        .upd_lvote  (res_lpred),
        .upd_gvote  (res_gpred),
        .upd_taken  (res_taken),
        .ch_en      (ch_en),
        .ch_dir     (ch_dir)
    );

endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
    parameter int LIDX_W    = 10,
    parameter int LHIST_LEN = 10,
    parameter int GHIST_LEN = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ready,
    input logic [LIDX_W-1:0]    fetch_slot,
    input logic                 pred_taken,
    input logic [LHIST_LEN-1:0] pred_lhist,
    input logic [GHIST_LEN-1:0] pred_ghist,
    input logic                 pred_lpred,
    input logic                 pred_gpred,
    input logic                 res_valid,
    input logic [LIDX_W-1:0]    res_slot,
    input logic                 res_taken,
    input logic [LHIST_LEN-2:0] res_lhist_lo,
    input logic [GHIST_LEN-2:0] res_ghist_lo
);
    // R1
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!pred_taken && pred_ghist == '0));

    // R6
    ghr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && res_valid) |=> pred_ghist == {$past(res_ghist_lo), $past(res_taken)});

    // R6
    ghr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !res_valid) |=> $stable(pred_ghist));

    // R7
    lhist_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && res_valid) |=> (fetch_slot != $past(res_slot)) ||
                                  (pred_lhist == {$past(res_lhist_lo), $past(res_taken)}));

    // R5
    vote_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && pred_lpred == pred_gpred) |-> pred_taken == pred_lpred);

endmodule

bind tournament_predictor tp_checker #(
    .LIDX_W    (LIDX_W),
    .LHIST_LEN (LHIST_LEN),
    .GHIST_LEN (GHIST_LEN)
) u_tp_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ready        (ready),
    .fetch_slot   (fetch_pc[PC_LSB +: LIDX_W]),
    .pred_taken   (pred_taken),
    .pred_lhist   (pred_lhist),
    .pred_ghist   (pred_ghist),
    .pred_lpred   (pred_lpred),
    .pred_gpred   (pred_gpred),
    .res_valid    (res_valid),
    .res_slot     (res_pc[PC_LSB +: LIDX_W]),
    .res_taken    (res_taken),
    .res_lhist_lo (res_lhist[LHIST_LEN-2:0]),
    .res_ghist_lo (res_ghist[GHIST_LEN-2:0])
);

// File: tb/tournament_predictor_bench.sv
module tournament_predictor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W   = 8;
    localparam int PC_LSB = 2;
    localparam int LIDX_W = 3;
    localparam int LHL    = 4;
    localparam int GHL    = 4;
    localparam int NSLOT  = 1 << LIDX_W;
    localparam int NLH    = 1 << LHL;
    localparam int NGH    = 1 << GHL;
    localparam int CLEAR_CYC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ready;
    logic [PC_W-1:0] fetch_pc = '0;
    logic pred_taken, pred_lpred, pred_gpred;
    logic [LHL-1:0] pred_lhist;
    logic [GHL-1:0] pred_ghist;
    logic res_valid = 1'b0;
    logic [PC_W-1:0] res_pc = '0;
    logic res_taken = 1'b0;
    logic [LHL-1:0] res_lhist = '0;
    logic [GHL-1:0] res_ghist = '0;
    logic res_lpred = 1'b0;
    logic res_gpred = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    int m_lht [NSLOT];
    int m_lpt [NLH];
    int m_gpt [NGH];
    int m_cht [NGH];
    int m_ghr;

    int p_pc, p_lh, p_gh, p_lp, p_gp;
    bit have_prev = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    tournament_predictor #(
        .PC_W(PC_W), .PC_LSB(PC_LSB), .LIDX_W(LIDX_W),
        .LHIST_LEN(LHL), .GHIST_LEN(GHL),
        .LCTR_W(3), .GCTR_W(2), .CCTR_W(2)
    ) u_tournament_predictor (
        .clk(clk), .rst_n(rst_n), .ready(ready), .fetch_pc(fetch_pc),
        .pred_taken(pred_taken), .pred_lhist(pred_lhist), .pred_ghist(pred_ghist),
        .pred_lpred(pred_lpred), .pred_gpred(pred_gpred),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_lhist(res_lhist), .res_ghist(res_ghist),
        .res_lpred(res_lpred), .res_gpred(res_gpred)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v, input bit up, input int mx);
        if (up) return (v == mx) ? v : v + 1;
        return (v == 0) ? v : v - 1;
    endfunction

    task automatic train(input int pc, input int lh, input int gh,
                         input int lp, input int gp, input bit t);
        int slot;
        slot = (pc >> PC_LSB) % NSLOT;
        m_lht[slot] = ((lh << 1) | int'(t)) % NLH;
        m_lpt[lh]   = sat(m_lpt[lh], t, 7);
        m_gpt[gh]   = sat(m_gpt[gh], t, 3);
        if (lp != gp) m_cht[gh] = sat(m_cht[gh], (gp == int'(t)), 3);
        m_ghr = ((gh << 1) | int'(t)) % NGH;
    endtask

    task automatic step(input int pc, input bit t, input bit stale);
        int slot, elh, elp, egp, ech, et;
        @(negedge clk);
        fetch_pc  = PC_W'(pc);
        res_valid = 1'b0;
        #1;
        slot = (pc >> PC_LSB) % NSLOT;
        elh = m_lht[slot];
        elp = (m_lpt[elh] >= 4) ? 1 : 0;
        egp = (m_gpt[m_ghr] >= 2) ? 1 : 0;
        ech = (m_cht[m_ghr] >= 2) ? 1 : 0;
        et  = ech ? egp : elp;
        chk("R2/R7 local history snapshot", int'(pred_lhist), elh);
        chk("R6 global history snapshot", int'(pred_ghist), m_ghr);
        chk("R3/R8 local vote", int'(pred_lpred), elp);
        chk("R4/R8 global vote", int'(pred_gpred), egp);
        chk("R5/R9/R10 final forecast", int'(pred_taken), et);
        res_valid = 1'b1;
        res_taken = t;
        if (stale && have_prev) begin
            res_pc = PC_W'(p_pc); res_lhist = LHL'(p_lh); res_ghist = GHL'(p_gh);
            res_lpred = p_lp[0]; res_gpred = p_gp[0];
            @(posedge clk); #1;
            res_valid = 1'b0;
            train(p_pc, p_lh, p_gh, p_lp, p_gp, t);
        end else begin
            res_pc = PC_W'(pc); res_lhist = LHL'(elh); res_ghist = GHL'(m_ghr);
            res_lpred = elp[0]; res_gpred = egp[0];
            @(posedge clk); #1;
            res_valid = 1'b0;
            train(pc, elh, m_ghr, elp, egp, t);
        end
        p_pc = pc; p_lh = elh; p_gh = m_ghr; p_lp = elp; p_gp = egp;
        have_prev = 1;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int cnt;
        for (int i = 0; i < NSLOT; i++) m_lht[i] = 0;
        for (int i = 0; i < NLH; i++) m_lpt[i] = 3;
        for (int i = 0; i < NGH; i++) begin m_gpt[i] = 1; m_cht[i] = 2; end
        m_ghr = 0;

        // R1: resolves presented throughout the sweep must be dropped
        res_valid = 1'b1; res_taken = 1'b1; res_pc = 8'h0C;
        res_lhist = 4'h5; res_ghist = 4'h3; res_lpred = 1'b1; res_gpred = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 ready in reset", int'(ready), 0);
        rst_n = 1'b1;
        cnt = 0;
        do begin
            @(posedge clk); #1;
            cnt++;
            if (!ready) chk("R1 forecast quiet during sweep", int'(pred_taken), 0);
        end while (!ready && cnt < 100);
        chk("R1 sweep length", cnt, CLEAR_CYC);
        res_valid = 1'b0;
        @(negedge clk); #1;
        chk("R1/R6 global history untouched by sweep-time resolve", int'(pred_ghist), 0);
        for (int s = 0; s < NSLOT; s++) begin
            fetch_pc = PC_W'(s << PC_LSB);
            #1;
            chk("R2 cleared local history", int'(pred_lhist), 0);
            chk("R3 local counter starts weakly not-taken", int'(pred_lpred), 0);
            chk("R4 global counter starts weakly not-taken", int'(pred_gpred), 0);
            chk("R5 cleared forecast", int'(pred_taken), 0);
        end

        // R3/R4/R8: saturate upward then downward on one branch
        for (int k = 0; k < 24; k++) step(32'h10, 1'b1, 1'b0);
        for (int k = 0; k < 24; k++) step(32'h10, 1'b0, 1'b0);

        // R9: periodic pattern on one branch interleaved with a biased one
        for (int k = 0; k < 40; k++) begin
            step(32'h24, (k % 3) != 2, 1'b0);
            step(32'h08, 1'b0, 1'b0);
        end

        // near-exhaustive sweep over slots and outcomes, some stale snapshots
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(int'(lfsr[4:2]) << PC_LSB, lfsr[7] | lfsr[9], lfsr[11:10] == 2'b00);
        end

        // R6: idle cycles hold the global history
        @(negedge clk); #1;
        cnt = int'(pred_ghist);
        repeat (3) @(negedge clk);
        #1;
        chk("R6 history held without resolve", int'(pred_ghist), m_ghr);
        chk("R6 history stable", int'(pred_ghist), cnt);

        summary();
        $finish;
    end

endmodule